// File: doc/BRIEF.md
# Load Return Path with Debug Character Window

This block sits between a core's load unit and a little-endian memory that answers in the same cycle. For each load request it takes the address, an access-size code and the memory's return word, and one cycle later it presents the load result to a big-endian core together with a fault flag. Loads need not be naturally aligned: a load is legal as long as every byte it touches lies inside one 16-byte line. A load that crosses a line boundary is reported as an alignment fault and returns zero.

Two fixed addresses are served by the block itself and never by memory. They form a small debug character port. The receive-data window at 0x7F000000 returns the last received byte and a receive-valid flag, and reading it clears the flag. The status window at 0x7F000004 always returns a constant that reports transmit space as available. A receive push from the debug side loads a new byte and sets the flag. Every other address is served from memory. The memory word is byte-reversed across the access width.

Top module: `load_path_unit`

## Requirements
- R1: A load whose first byte and last byte fall in different 16-byte lines (address bits 63..4 differ) raises `ld_fault` with `ld_data` equal to zero. An address range that wraps past the top of the address space also counts as a fault.
- R2: A load that is unaligned for its size but stays inside one 16-byte line completes without a fault.
- R3: A load at 0x7F000000 returns a word that is zero except for the held receive byte in bits 31..24 and the receive-valid flag in bit 23. This word is not byte-reversed.
- R4: A load at 0x7F000000 clears the receive-valid flag for later loads. The held byte is kept.
- R5: A load at 0x7F000004 returns 0x000000000004FFFF whatever the memory word and the size code are.
- R6: A receive push loads `rx_byte` and sets the receive-valid flag. When a push and a receive-data load fall in the same cycle, that load returns the state from before the push, and the flag stays set with the new byte.
- R7: For other addresses, the size code (0=1, 1=2, 2=4, 3=8 bytes) selects N bytes. Result byte i is memory byte N-1-i, with byte 0 in bits 7..0.
- R8: For 1-, 2- and 4-byte loads from memory, the result bits at and above 8*N are zero.
- R9: `ld_rsp_valid` is high in exactly the cycle after `ld_valid` is high. After reset all outputs are zero and the receive-valid flag is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | Load request this cycle |
| ld_addr | input | 64 | Byte address of the load |
| ld_size | input | 2 | Size code: 0=1, 1=2, 2=4, 3=8 bytes |
| mem_rdata | input | 64 | Little-endian memory word for the current request |
| rx_push | input | 1 | Debug side delivers a received byte |
| rx_byte | input | 8 | Received byte |
| ld_rsp_valid | output | 1 | Load result valid |
| ld_data | output | 64 | Load result |
| ld_fault | output | 1 | Load crossed a 16-byte line |

## Verification
The hardest case to reach is a receive push that lands in the same cycle as a receive-data load, because the returned word and the later flag state then follow different rules. The stimulus first leaves a known byte with the flag cleared. It then drives the push and the load on the same falling edge, checks that the response still shows the old byte with the flag clear, and issues a second load to show that the new byte and the set flag were kept. The boundary of the line check is probed with loads that end exactly on the last byte of a line, loads that end one byte past it, and a load that wraps past the top of the address space.

// File: rtl/ldpath_pkg.sv
package ldpath_pkg;
    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_HALF  = 2'd1,
        SZ_WORD  = 2'd2,
        SZ_DWORD = 2'd3
    } acc_size_e;

    typedef struct packed {
        logic        valid;
        logic [7:0]  data;
    } rx_state_t;
endpackage

// File: rtl/line_span_check.sv
module line_span_check #(
    parameter int ADDR_W     = 64,
    parameter int LINE_BYTES = 16,
    parameter int SIZE_W     = 2
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [SIZE_W-1:0] size_code,
    output logic              crosses
);
    localparam int LINE_LOG = $clog2(LINE_BYTES);

    logic [ADDR_W-1:0] last_byte;
    logic [ADDR_W:0]   end_wide;
    logic [ADDR_W:0]   span;

    always_comb begin
        span      = ({{ADDR_W{1'b0}}, 1'b1} << size_code) - 1'b1;
        end_wide  = {1'b0, addr} + span;
        last_byte = end_wide[ADDR_W-1:0];
        // a carry out of the top bit means the range wrapped
        crosses   = end_wide[ADDR_W] ||
                    (addr[ADDR_W-1:LINE_LOG] != last_byte[ADDR_W-1:LINE_LOG]);
    end
endmodule

// File: rtl/width_reverse.sv
module width_reverse #(
    parameter int DATA_W = 64,
    parameter int SIZE_W = 2
) (
    input  logic [DATA_W-1:0] din,
    input  logic [SIZE_W-1:0] size_code,
    output logic [DATA_W-1:0] dout
);
    localparam int NBYTES = DATA_W / 8;
    localparam int NVAR   = $clog2(NBYTES) + 1;

    logic [DATA_W-1:0] variant [NVAR];

    for (genvar g = 0; g < NVAR; g++) begin : g_size
        localparam int N = 1 << g;
        for (genvar b = 0; b < NBYTES; b++) begin : g_byte
            if (b < N) begin : g_live
                assign variant[g][8*b +: 8] = din[8*(N-1-b) +: 8];
            end else begin : g_zero
                assign variant[g][8*b +: 8] = 8'h00;
            end
        end
    end

    always_comb begin
        dout = '0;
        for (int k = 0; k < NVAR; k++) begin
            if (int'(size_code) == k) dout = variant[k];
        end
    end
endmodule

// File: rtl/rx_holding.sv
module rx_holding
    import ldpath_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       push,
    input  logic [7:0] push_byte,
    input  logic       read_clear,
    output rx_state_t  state_q
);
    rx_state_t state_d;

    always_comb begin
        state_d = state_q;
        if (read_clear) state_d.valid = 1'b0;
        if (push) begin
            state_d.valid = 1'b1;
            state_d.data  = push_byte;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    p_push_sets_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> (state_q.valid && state_q.data == $past(push_byte)));

    p_read_clears_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (read_clear && !push) |=> (!state_q.valid && $stable(state_q.data)));
endmodule

// File: rtl/load_path_unit.sv
module load_path_unit
    import ldpath_pkg::*;
#(
    parameter int              ADDR_W       = 64,
    parameter int              DATA_W       = 64,
    parameter int              LINE_BYTES   = 16,
    parameter logic [63:0]     RX_DATA_ADDR = 64'h0000_0000_7F00_0000,
    parameter logic [63:0]     RX_STAT_ADDR = 64'h0000_0000_7F00_0004,
    parameter logic [63:0]     STAT_WORD    = 64'h0000_0000_0004_FFFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_valid,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [1:0]        ld_size,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              rx_push,
    input  logic [7:0]        rx_byte,
    output logic              ld_rsp_valid,
    output logic [DATA_W-1:0] ld_data,
    output logic              ld_fault
);
    localparam int SIZE_W    = 2;
    localparam int BYTE_POS  = 24;
    localparam int FLAG_POS  = 23;

    typedef struct packed {
        logic              rsp;
        logic              fault;
        logic [DATA_W-1:0] data;
    } rsp_t;

    rsp_t              rsp_d, rsp_q;
    logic              crosses;
    logic [DATA_W-1:0] swapped;
    logic              hit_data, hit_stat, rd_clear;
    rx_state_t         rx_q;

    line_span_check #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .SIZE_W(SIZE_W)) span_i (
        .addr(ld_addr), .size_code(ld_size), .crosses(crosses));

    width_reverse #(.DATA_W(DATA_W), .SIZE_W(SIZE_W)) rev_i (
        .din(mem_rdata), .size_code(ld_size), .dout(swapped));

    always_comb begin
        hit_data = (ld_addr == RX_DATA_ADDR[ADDR_W-1:0]);
        hit_stat = (ld_addr == RX_STAT_ADDR[ADDR_W-1:0]);
        rd_clear = ld_valid && !crosses && hit_data;
    end

    rx_holding rx_i (
        .clk(clk), .rst_n(rst_n), .push(rx_push), .push_byte(rx_byte),
        .read_clear(rd_clear), .state_q(rx_q));

    always_comb begin
        rsp_d       = '0;
        rsp_d.rsp   = ld_valid;
        if (ld_valid) begin
            if (crosses) begin
                rsp_d.fault = 1'b1;
            end else if (hit_data) begin
                rsp_d.data[BYTE_POS +: 8] = rx_q.data;
                rsp_d.data[FLAG_POS]      = rx_q.valid;
            end else if (hit_stat) begin
                rsp_d.data = STAT_WORD[DATA_W-1:0];
            end else begin
                rsp_d.data = swapped;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign ld_rsp_valid = rsp_q.rsp;
    assign ld_data      = rsp_q.data;
    assign ld_fault     = rsp_q.fault;

    p_fault_zero_data_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ld_fault |-> (ld_data == '0 && ld_rsp_valid));

    p_status_constant_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && ld_addr == RX_STAT_ADDR[ADDR_W-1:0]) |=>
            (ld_data == STAT_WORD[DATA_W-1:0] && !ld_fault));

    p_rsp_follows_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid |=> ld_rsp_valid);

    p_no_rsp_without_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_valid |=> !ld_rsp_valid);

    p_narrow_upper_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && ld_size == SZ_BYTE && !hit_data && !hit_stat) |=>
            (ld_data[DATA_W-1:8] == '0));
endmodule

// File: tb/load_path_unit_tb_top.sv
module load_path_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_valid = 1'b0;
    logic [63:0] ld_addr = '0;
    logic [1:0]  ld_size = '0;
    logic [63:0] mem_rdata = '0;
    logic        rx_push = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        ld_rsp_valid;
    logic [63:0] ld_data;
    logic        ld_fault;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    load_path_unit dut_i (
        .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_addr(ld_addr),
        .ld_size(ld_size), .mem_rdata(mem_rdata), .rx_push(rx_push),
        .rx_byte(rx_byte), .ld_rsp_valid(ld_rsp_valid), .ld_data(ld_data),
        .ld_fault(ld_fault));

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] model_rev(input logic [63:0] d, input int sz);
        logic [63:0] r = '0;
        int n = 1 << sz;
        for (int i = 0; i < n; i++) r = r | (64'((d >> (8*(n-1-i))) & 64'hFF) << (8*i));
        return r;
    endfunction

    // drive one load, return the sampled response
    task automatic do_load(input logic [63:0] a, input logic [1:0] s, input logic [63:0] m,
                           output logic [63:0] d, output logic f, output logic v);
        @(negedge clk);
        ld_valid = 1'b1; ld_addr = a; ld_size = s; mem_rdata = m;
        @(negedge clk);
        ld_valid = 1'b0; mem_rdata = '0;
        d = ld_data; f = ld_fault; v = ld_rsp_valid;
    endtask

    task automatic t_reset();
        check("R9 reset rsp", 64'(ld_rsp_valid), 64'd0);
        check("R9 reset data", ld_data, 64'd0);
        check("R9 reset fault", 64'(ld_fault), 64'd0);
    endtask

    task automatic t_line_span();
        logic [63:0] d; logic f, v;
        do_load(64'h1000_000F, 2'd1, 64'hFFFF, d, f, v);
        check("R1 half crosses fault", 64'(f), 64'd1);
        check("R1 fault data zero", d, 64'd0);
        do_load(64'h2009, 2'd3, 64'h1122334455667788, d, f, v);
        check("R1 dword at 9 fault", 64'(f), 64'd1);
        do_load(64'hFFFF_FFFF_FFFF_FFFE, 2'd2, 64'h1, d, f, v);
        check("R1 wrap fault", 64'(f), 64'd1);
        do_load(64'h2008, 2'd3, 64'h0123456789ABCDEF, d, f, v);
        check("R2 dword ends on line edge", 64'(f), 64'd0);
        check("R2 dword data", d, 64'hEFCDAB8967452301);
        do_load(64'h3003, 2'd2, 64'hAABBCCDD, d, f, v);
        check("R2 unaligned word no fault", 64'(f), 64'd0);
        check("R2 unaligned word data", d, 64'hDDCCBBAA);
    endtask

    task automatic t_memory();
        logic [63:0] d; logic f, v;
        logic [63:0] pat = 64'h0123456789ABCDEF;
        for (int s = 0; s < 4; s++) begin
            do_load(64'h4000, 2'(s), pat, d, f, v);
            check("R7 reversed width", d, model_rev(pat, s));
            check("R9 rsp valid", 64'(v), 64'd1);
        end
        do_load(64'h4010, 2'd0, 64'hFFFF_FFFF_FFFF_FF5A, d, f, v);
        check("R8 byte upper zero", d, 64'h5A);
        do_load(64'h4010, 2'd1, 64'hFFFF_FFFF_FFFF_1234, d, f, v);
        check("R8 half upper zero", d, 64'h3412);
        @(negedge clk);
        check("R9 no rsp when idle", 64'(ld_rsp_valid), 64'd0);
    endtask

    task automatic t_status();
        logic [63:0] d; logic f, v;
        do_load(64'h7F00_0004, 2'd3, 64'hDEAD_BEEF_0000_0000, d, f, v);
        check("R5 status dword", d, 64'h0004FFFF);
        do_load(64'h7F00_0004, 2'd0, 64'h77, d, f, v);
        check("R5 status byte size", d, 64'h0004FFFF);
    endtask

    task automatic t_rx();
        logic [63:0] d; logic f, v;
        do_load(64'h7F00_0000, 2'd3, 64'hFFFF_FFFF_FFFF_FFFF, d, f, v);
        check("R3 empty window", d, 64'd0);
        @(negedge clk); rx_push = 1'b1; rx_byte = 8'hA5;
        @(negedge clk); rx_push = 1'b0;
        do_load(64'h7F00_0000, 2'd3, 64'h1234, d, f, v);
        check("R3 R6 byte and flag", d, 64'hA580_0000);
        do_load(64'h7F00_0000, 2'd3, 64'h0, d, f, v);
        check("R4 flag cleared byte kept", d, 64'hA500_0000);
        // push and read in the same cycle
        @(negedge clk);
        ld_valid = 1'b1; ld_addr = 64'h7F00_0000; ld_size = 2'd3;
        rx_push = 1'b1; rx_byte = 8'h3C;
        @(negedge clk);
        ld_valid = 1'b0; rx_push = 1'b0;
        check("R6 same cycle returns old", ld_data, 64'hA500_0000);
        do_load(64'h7F00_0000, 2'd2, 64'h0, d, f, v);
        check("R6 push wins over clear", d, 64'h3C80_0000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_line_span();
        t_memory();
        t_status();
        t_rx();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++; fails++;
                $display("FAIL watchdog actual=hung expected=done");
            end
        join_any
        $display("  test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end
endmodule